// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the pins of a serial peripheral slave and the shift engine behind it. It lets the bus master pause a transaction in the middle of a byte, with an active-low pause input. While the pause is in force, serial clock edges do not reach the engine, so data input changes have no effect on it. The engine keeps its bit count and shift contents, and the transaction carries on from the same bit once the pause ends. The pause input also takes the data output off the bus.

All pin inputs are first brought into the system clock domain through a chain of flops whose depth is a parameter. The clock, select and pause inputs are then read as levels and edges in that domain. The pause starts and ends only while the serial clock is low. If the pause input changes while the clock is high, the change waits for the clock to go low. The select input keeps working during a pause. Deselecting clears the pause and holds the engine in its idle state.

The engine receives one-cycle enables for the rising and falling edges of the serial clock, the synchronized data input, and an idle level. It returns the bit it wants to send and a request to drive. The block turns these into the data output and its output enable.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, with select high (deselected), the pause input high and the serial clock low, `paused_o`=0, `eng_idle_o`=1, `so_oe_o`=0, and neither edge enable is active.
- R2: If the pause input goes low while the serial clock is low and the block is selected, `paused_o` becomes 1 without waiting for any clock edge. From then on, neither edge enable pulses.
- R3: If the pause input goes low while the serial clock is high, `paused_o` stays 0 until the clock falls. That falling edge is still passed to the engine as one `eng_fall_o` pulse, and `paused_o` is 1 from the next cycle on.
- R4: While `paused_o`=1, serial clock pulses produce no `eng_rise_o` or `eng_fall_o` pulse, whatever the data input does.
- R5: Raising the pause input while the serial clock is high leaves `paused_o`=1. The pause ends only once the pause input is high and the clock is low. A falling edge that arrives while still paused is not passed to the engine.
- R6: After a pause ends, each later serial clock pulse again gives exactly one rising-edge pulse and one falling-edge pulse. Over a whole sequence, the number of rising-edge pulses the engine receives equals the number of clock pulses given outside the pause.
- R7: Whenever the synchronized pause input is low, `so_oe_o`=0. This holds even before the pause has taken effect.
- R8: A high select input clears the pause, drives `eng_idle_o`=1 and `so_oe_o`=0, and blocks both edge enables.
- R9: When selected, not paused and with the pause input high, `so_oe_o` equals `eng_oe_i` and `so_o` equals `eng_so_i`. `eng_si_o` follows the data input pin after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| si_i | input | 1 | Serial data input pin |
| eng_so_i | input | 1 | Bit the engine wants to send |
| eng_oe_i | input | 1 | Engine request to drive the output |
| eng_rise_o | output | 1 | One-cycle qualified rising-edge enable |
| eng_fall_o | output | 1 | One-cycle qualified falling-edge enable |
| eng_si_o | output | 1 | Synchronized data input to the engine |
| eng_idle_o | output | 1 | Holds the engine in idle (deselected) |
| so_o | output | 1 | Serial data output value |
| so_oe_o | output | 1 | Serial data output enable |
| paused_o | output | 1 | Pause in force |

## Verification
The pause can begin on the very cycle in which a falling clock edge is seen. The bench provokes this by lowering the pause input while the clock is high and then dropping the clock. It then checks that this one fall still reaches the engine and that the pause is in force from the next cycle. The release can also fall on the same cycle as a falling edge. This is provoked by raising the pause input while the clock is high and then dropping the clock. The check is that the pause clears without that fall reaching the engine, so the rising and falling edge counts stay paired.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   localparam int PIN_W   = 4;
   localparam int IDX_SCK = 0;
   localparam int IDX_CS  = 1;
   localparam int IDX_HLD = 2;
   localparam int IDX_SI  = 3;
   // idle pin levels: deselected, pause released, clock low, data low
   localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;

   typedef enum logic {ST_RUN = 1'b0, ST_PAUSE = 1'b1} pause_st_e;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 2) $error("spi_hold_sync: STAGES must be at least 2");
      if (W < 1) $error("spi_hold_sync: W must be positive");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic block_i,
   output logic sck_fell_o,
   output logic rise_en_o,
   output logic fall_en_o
);
   logic sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_fell_o = sck_d & ~sck_s;
   assign rise_en_o  = ~sck_d & sck_s & ~block_i;
   assign fall_en_o  = sck_fell_o & ~block_i;
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic cs_n_s,
   input  logic hold_n_s,
   output logic paused_o
);
   pause_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (cs_n_s) begin
         st_d = ST_RUN;
      end else if (!sck_s) begin
         // both entry and exit are only taken with the serial clock low
         st_d = hold_n_s ? ST_RUN : ST_PAUSE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   assign paused_o = (st_q == ST_PAUSE);

   assert_enter_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused_o) |-> $past(!sck_s && !hold_n_s && !cs_n_s));

   assert_exit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(paused_o) && !$past(cs_n_s)) |-> $past(!sck_s && hold_n_s));

   assert_desel_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !paused_o);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic hold_n_i,
   input  logic si_i,
   input  logic eng_so_i,
   input  logic eng_oe_i,
   output logic eng_rise_o,
   output logic eng_fall_o,
   output logic eng_si_o,
   output logic eng_idle_o,
   output logic so_o,
   output logic so_oe_o,
   output logic paused_o
);
   logic [PIN_W-1:0] pin_raw, pin_s;
   logic sck_s, cs_n_s, hold_n_s;
   logic paused, sck_fell;

   initial begin
      if (SYNC_STAGES < 2) $error("spi_hold_ctrl: SYNC_STAGES below 2");
   end

   always_comb begin
      pin_raw          = '0;
      pin_raw[IDX_SCK] = sck_i;
      pin_raw[IDX_CS]  = cs_n_i;
      pin_raw[IDX_HLD] = hold_n_i;
      pin_raw[IDX_SI]  = si_i;
   end

   spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_raw), .q_o(pin_s));

   assign sck_s    = pin_s[IDX_SCK];
   assign cs_n_s   = pin_s[IDX_CS];
   assign hold_n_s = pin_s[IDX_HLD];

   spi_hold_pause u_pause (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
      .hold_n_s(hold_n_s), .paused_o(paused));

   spi_hold_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .block_i(paused | cs_n_s),
      .sck_fell_o(sck_fell), .rise_en_o(eng_rise_o), .fall_en_o(eng_fall_o));

   assign eng_si_o   = pin_s[IDX_SI];
   assign eng_idle_o = cs_n_s;
   assign paused_o   = paused;
   assign so_o       = eng_so_i;
   assign so_oe_o    = eng_oe_i & ~cs_n_s & hold_n_s & ~paused;

   assert_no_edge_paused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      paused_o |-> (!eng_rise_o && !eng_fall_o));

   assert_hold_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_n_s |-> !so_oe_o);

   assert_desel_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_idle_o |-> (!so_oe_o && !eng_rise_o && !eng_fall_o));

   assert_fall_at_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(paused_o) && $past(sck_fell)) |-> $past(eng_fall_o));
endmodule

// File: tb/spi_hold_ctrl_tb_top.sv
module spi_hold_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
   logic eso = 1'b0, eoe = 1'b0;
   logic rise_o, fall_o, si_o, idle_o, so_o, so_oe_o, paused_o;
   int   n_chk = 0, n_bad = 0;
   int   rise_cnt = 0, fall_cnt = 0;
   localparam int SETTLE = 6;

   always #10 clk = ~clk;

   spi_hold_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
      .si_i(si), .eng_so_i(eso), .eng_oe_i(eoe), .eng_rise_o(rise_o),
      .eng_fall_o(fall_o), .eng_si_o(si_o), .eng_idle_o(idle_o), .so_o(so_o),
      .so_oe_o(so_oe_o), .paused_o(paused_o));

   always @(negedge clk) begin
      if (rise_o) rise_cnt++;
      if (fall_o) fall_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) sck = 1'b1; si = ~si; wait_n(SETTLE);
         @(negedge clk) sck = 1'b0; wait_n(SETTLE);
      end
   endtask

   task automatic clr_cnt;
      wait_n(1); rise_cnt = 0; fall_cnt = 0;
   endtask

   task automatic t_reset;
      wait_n(2);
      chk("R1 paused", paused_o, 0);
      chk("R1 idle", idle_o, 1);
      chk("R1 so_oe", so_oe_o, 0);
      chk("R1 edges", rise_o | fall_o, 0);
   endtask

   task automatic t_run;
      @(negedge clk) cs_n = 1'b0; eoe = 1'b1; eso = 1'b1; wait_n(SETTLE);
      chk("R9 so_oe", so_oe_o, 1);
      chk("R9 so", so_o, 1);
      chk("R8 idle low", idle_o, 0);
      clr_cnt(); pulses(8);
      chk("R6 rise count", rise_cnt, 8);
      chk("R6 fall count", fall_cnt, 8);
      @(negedge clk) si = 1'b1; wait_n(SETTLE);
      chk("R9 si pass", si_o, 1);
   endtask

   task automatic t_pause_low;
      clr_cnt();
      @(negedge clk) hold_n = 1'b0; wait_n(SETTLE);
      chk("R2 paused", paused_o, 1);
      chk("R7 so_oe", so_oe_o, 0);
      pulses(3);
      chk("R4 rise blocked", rise_cnt, 0);
      chk("R4 fall blocked", fall_cnt, 0);
      @(negedge clk) hold_n = 1'b1; wait_n(SETTLE);
      chk("R6 resumed", paused_o, 0);
      chk("R9 so_oe back", so_oe_o, 1);
      pulses(2);
      chk("R6 rise after", rise_cnt, 2);
      chk("R6 fall after", fall_cnt, 2);
   endtask

   task automatic t_pause_high;
      clr_cnt();
      @(negedge clk) sck = 1'b1; wait_n(SETTLE);
      @(negedge clk) hold_n = 1'b0; wait_n(SETTLE);
      chk("R3 not yet paused", paused_o, 0);
      chk("R7 early tristate", so_oe_o, 0);
      chk("R3 rise seen", rise_cnt, 1);
      @(negedge clk) sck = 1'b0; wait_n(SETTLE);
      chk("R3 paused after fall", paused_o, 1);
      chk("R3 fall delivered", fall_cnt, 1);
      pulses(2);
      chk("R4 rise blocked", rise_cnt, 1);
      // release while clock high
      @(negedge clk) sck = 1'b1; wait_n(SETTLE);
      @(negedge clk) hold_n = 1'b1; wait_n(SETTLE);
      chk("R5 still paused", paused_o, 1);
      chk("R5 no rise", rise_cnt, 1);
      @(negedge clk) sck = 1'b0; wait_n(SETTLE);
      chk("R5 released", paused_o, 0);
      chk("R5 fall swallowed", fall_cnt, 1);
      pulses(3);
      chk("R6 rise total", rise_cnt, 4);
      chk("R6 fall total", fall_cnt, 4);
   endtask

   task automatic t_desel;
      clr_cnt();
      @(negedge clk) hold_n = 1'b0; wait_n(SETTLE);
      chk("R2 paused again", paused_o, 1);
      @(negedge clk) cs_n = 1'b1; wait_n(SETTLE);
      chk("R8 pause cleared", paused_o, 0);
      chk("R8 idle", idle_o, 1);
      @(negedge clk) hold_n = 1'b1; wait_n(SETTLE);
      pulses(2);
      chk("R8 edges blocked", rise_cnt + fall_cnt, 0);
      chk("R8 so_oe", so_oe_o, 0);
      @(negedge clk) cs_n = 1'b0; wait_n(SETTLE);
      pulses(1);
      chk("R6 reselect edges", rise_cnt, 1);
   endtask

   initial begin
      fork
         begin
            wait_n(3); rst_n = 1'b1;
            t_reset(); t_run(); t_pause_low(); t_pause_high(); t_desel();
         end
         begin
            wait_n(20000);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule